// File: doc/BRIEF.md
# Three-Wire Serial Byte EEPROM Model

This block is a synthesizable stand-in for a small three-wire serial EEPROM of 128 bytes. A host drives chip select, a serial clock and a serial data line. The block drives one data line back. All four pins are sampled on the block's own system clock, so the serial clock must be several system clocks slow. Each transfer begins with a start bit. Two opcode bits and a 7-bit address follow, and a write carries one more data byte. A read sends back a dummy zero and then the addressed byte.

Programming commands are write, erase, erase-all and write-all. They take effect only while a write-enable latch is set. They are launched when chip select drops after a complete instruction. The block then stays busy for a parameterised number of system clocks. While busy, a host that raises chip select sees the data line low. It sees the line high once programming has finished. Any instruction that starts while the block is busy is discarded.

Top module: `mw_eeprom`

## Requirements
- R1: After reset every location reads 0xFF, the enable latch is clear and the block is not busy, so raising chip select with no instruction shows dout high.
- R2: While the enable latch is clear, write, erase, erase-all and write-all change no location and start no busy period.
- R3: Bits are taken on rising serial clock edges while chip select is high. Zeros before the first 1 are skipped, and that 1 is the start bit. The next two bits are the opcode, high bit first. The 7 address bits follow, A6 first.
- R4: Opcode 10 is a read. From the rising edge of A0 dout shows a dummy 0. Each following falling edge of the serial clock after that bit period moves dout to the next data bit, bit 7 first.
- R5: A complete programming instruction starts programming when chip select falls. Starting one system clock later, the block is busy for PROG_CYCLES clocks. With chip select high and no read in progress, dout is low while busy and high otherwise.
- R6: Opcode 01 is a write. Eight data bits follow the address, bit 7 first, and they go to the addressed location.
- R7: A start bit seen while busy makes the block ignore the rest of that chip-select window.
- R8: Opcode 11 sets the addressed location to 0xFF and leaves the other locations as they were.
- R9: Opcode 00 with address bits A6..A5 = 10 sets every location to 0xFF.
- R10: Opcode 00 with A6..A5 = 01, followed by 8 data bits, writes that byte to every location.
- R11: Opcode 00 with A6..A5 = 11 sets the enable latch. With A6..A5 = 00 it clears the latch. Neither makes the block busy.
- R12: If chip select drops before an instruction is complete, the instruction is abandoned. No location changes and no busy period starts.
- R13: While chip select is low, dout is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| dout | output | 1 | Serial read data and ready/busy status |

## Verification
A corrupted instruction shifter or address register shows at the ports within one read. The wrong byte comes back, or the wrong location changes, and a full sweep of all 128 addresses reveals it. A stuck enable latch shows immediately: a locked write pulls dout low when chip select is raised again, or an unlocked one leaves dout high. A wrong busy count moves the low-to-high edge of dout away from the expected system-clock cycle. A missed busy gate shows on the next read as an overwritten byte.

// File: rtl/mw_eeprom_pkg.sv
// Shared encodings for the serial EEPROM model.
// Assumes opcode and extended-code values fixed by the serial protocol.
package mw_eeprom_pkg;

    // Receive phase of the serial front end
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HEAD,
        PH_WDATA,
        PH_READ,
        PH_HOLD
    } phase_t;

    // Programming action waiting for chip select to fall
    typedef enum logic [2:0] {
        PK_NONE,
        PK_WRITE,
        PK_ERASE,
        PK_ERASE_ALL,
        PK_WRITE_ALL
    } prog_kind_t;

    // Two-bit opcode values
    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    // Extended codes carried in the two top address bits
    localparam logic [1:0] EXT_LOCK   = 2'b00;
    localparam logic [1:0] EXT_WRALL  = 2'b01;
    localparam logic [1:0] EXT_ERALL  = 2'b10;
    localparam logic [1:0] EXT_UNLOCK = 2'b11;

endpackage

// File: rtl/mw_pin_sync.sv
// Registers the three host pins once and derives edge strobes.
// Assumes the host pins are already synchronous to clk and that the
// serial clock stays stable for at least two system clocks per level.
module mw_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic cs_s,
    output logic di_s,
    output logic sk_rise,
    output logic sk_fall,
    output logic cs_fall
);

    logic cs_q, cs_q2, sk_q, sk_q2, di_q;

    // Capture pins and keep one cycle of history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q  <= 1'b0;
            cs_q2 <= 1'b0;
            sk_q  <= 1'b0;
            sk_q2 <= 1'b0;
            di_q  <= 1'b0;
        end else begin
            cs_q  <= cs;
            cs_q2 <= cs_q;
            sk_q  <= sk;
            sk_q2 <= sk_q;
            di_q  <= di;
        end
    end

    assign cs_s    = cs_q;
    assign di_s    = di_q;
    assign sk_rise = cs_q & sk_q & ~sk_q2;
    assign sk_fall = cs_q & ~sk_q & sk_q2;
    assign cs_fall = cs_q2 & ~cs_q;

endmodule

// File: rtl/mw_busy_timer.sv
// Self-timed programming interval: busy for PROG_CYCLES clocks after start.
// Assumes start is never pulsed while busy is already high.
module mw_busy_timer #(
    parameter int PROG_CYCLES = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] remain;

    // Load the interval on start, count down to zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= CW'(PROG_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/mw_cell_array.sv
// Byte storage with one combinational read port and one write port that
// can hit a single location or every location in the same cycle.
// Assumes reset stands for a freshly erased part (all ones).
module mw_cell_array #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_all,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DEPTH-1:0]  hit;

    // One select line per location: bulk write or address match
    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
        assign hit[g] = wr_en & (wr_all | (wr_addr == ADDR_W'(g)));
    end

    // Update every selected location; reset to the erased value
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                cells[i] <= '1;
            end else if (hit[i]) begin
                cells[i] <= wr_data;
            end
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/mw_serial_ctrl.sv
// Instruction shifter, decoder, enable latch and read-out shifter.
// Assumes pin strobes from mw_pin_sync and a combinational array read.
// A programming action is only armed here; it launches on chip-select fall.
module mw_serial_ctrl
    import mw_eeprom_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              di_s,
    input  logic              sk_rise,
    input  logic              sk_fall,
    input  logic              cs_fall,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              prog_go,
    output logic              prog_all,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              read_active,
    output logic              read_bit,
    output logic              wen
);

    localparam int HDR_W = ADDR_W + 2;
    localparam int MAXB  = (HDR_W > DATA_W) ? HDR_W : DATA_W;
    localparam int CNT_W = $clog2(MAXB + 1);

    phase_t            phase;
    prog_kind_t        pend;
    logic [CNT_W-1:0]  cnt;
    logic [HDR_W-1:0]  hdr;
    logic [DATA_W-1:0] wbuf;
    logic [DATA_W:0]   rbuf;
    logic [ADDR_W-1:0] paddr;
    logic [DATA_W-1:0] pdata;
    logic              wall;
    logic              rd_skip;

    logic [HDR_W-1:0]  hdr_next;
    logic [DATA_W-1:0] wbuf_next;
    logic [1:0]        hdr_op;
    logic [1:0]        hdr_ext;
    logic [ADDR_W-1:0] hdr_addr;

    // Next shift values and decoded fields of the incoming header
    always_comb begin
        hdr_next  = {hdr[HDR_W-2:0], di_s};
        wbuf_next = {wbuf[DATA_W-2:0], di_s};
        hdr_op    = hdr_next[HDR_W-1:HDR_W-2];
        hdr_addr  = hdr_next[ADDR_W-1:0];
        hdr_ext   = hdr_addr[ADDR_W-1:ADDR_W-2];
    end

    // Receive state machine, enable latch and read shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            pend    <= PK_NONE;
            cnt     <= '0;
            hdr     <= '0;
            wbuf    <= '0;
            rbuf    <= '0;
            paddr   <= '0;
            pdata   <= '0;
            wall    <= 1'b0;
            rd_skip <= 1'b0;
            wen     <= 1'b0;
        end else if (!cs_s) begin
            phase   <= PH_IDLE;
            pend    <= PK_NONE;
            cnt     <= '0;
            rd_skip <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (sk_rise && di_s) begin
                        phase <= busy ? PH_HOLD : PH_HEAD;
                        cnt   <= '0;
                        hdr   <= '0;
                    end
                end
                PH_HEAD: begin
                    if (sk_rise) begin
                        hdr <= hdr_next;
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(HDR_W - 1)) begin
                            cnt   <= '0;
                            phase <= PH_HOLD;
                            case (hdr_op)
                                OPC_READ: begin
                                    rbuf    <= {1'b0, rd_data};
                                    rd_skip <= 1'b1;
                                    phase   <= PH_READ;
                                end
                                OPC_WRITE: begin
                                    paddr <= hdr_addr;
                                    wall  <= 1'b0;
                                    phase <= PH_WDATA;
                                end
                                OPC_ERASE: begin
                                    paddr <= hdr_addr;
                                    if (wen) pend <= PK_ERASE;
                                end
                                default: begin
                                    case (hdr_ext)
                                        EXT_UNLOCK: wen <= 1'b1;
                                        EXT_LOCK:   wen <= 1'b0;
                                        EXT_ERALL:  if (wen) pend <= PK_ERASE_ALL;
                                        default: begin
                                            wall  <= 1'b1;
                                            phase <= PH_WDATA;
                                        end
                                    endcase
                                end
                            endcase
                        end
                    end
                end
                PH_WDATA: begin
                    if (sk_rise) begin
                        wbuf <= wbuf_next;
                        cnt  <= cnt + 1'b1;
                        if (cnt == CNT_W'(DATA_W - 1)) begin
                            pdata <= wbuf_next;
                            phase <= PH_HOLD;
                            if (wen) pend <= wall ? PK_WRITE_ALL : PK_WRITE;
                        end
                    end
                end
                PH_READ: begin
                    if (sk_fall) begin
                        if (rd_skip) rd_skip <= 1'b0;
                        else         rbuf    <= {rbuf[DATA_W-1:0], 1'b0};
                    end
                end
                PH_HOLD: begin
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign rd_addr     = hdr_addr;
    assign prog_go     = cs_fall && (pend != PK_NONE);
    assign prog_all    = (pend == PK_ERASE_ALL) || (pend == PK_WRITE_ALL);
    assign prog_addr   = paddr;
    assign prog_data   = ((pend == PK_ERASE) || (pend == PK_ERASE_ALL)) ? '1 : pdata;
    assign read_active = (phase == PH_READ);
    assign read_bit    = rbuf[DATA_W];

endmodule

// File: rtl/mw_eeprom.sv
// Top level of the serial EEPROM model: pin capture, control, storage and
// programming timer. dout carries read data during a read, ready/busy
// status otherwise, and is 0 while chip select is low.
// Assumes a serial clock much slower than clk.
module mw_eeprom #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic dout
);

    logic              cs_s, di_s, sk_rise, sk_fall, cs_fall;
    logic              busy, prog_go, prog_all, read_active, read_bit, wen;
    logic [ADDR_W-1:0] rd_addr, prog_addr;
    logic [DATA_W-1:0] rd_data, prog_data;

    mw_pin_sync u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .sk      (sk),
        .di      (di),
        .cs_s    (cs_s),
        .di_s    (di_s),
        .sk_rise (sk_rise),
        .sk_fall (sk_fall),
        .cs_fall (cs_fall)
    );

    mw_serial_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_s        (cs_s),
        .di_s        (di_s),
        .sk_rise     (sk_rise),
        .sk_fall     (sk_fall),
        .cs_fall     (cs_fall),
        .busy        (busy),
        .rd_data     (rd_data),
        .rd_addr     (rd_addr),
        .prog_go     (prog_go),
        .prog_all    (prog_all),
        .prog_addr   (prog_addr),
        .prog_data   (prog_data),
        .read_active (read_active),
        .read_bit    (read_bit),
        .wen         (wen)
    );

    mw_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (prog_go),
        .wr_all  (prog_all),
        .wr_addr (prog_addr),
        .wr_data (prog_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    mw_busy_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (prog_go),
        .busy  (busy)
    );

    // Output select: read data, else ready status, gated by chip select
    assign dout = cs_s & (read_active ? read_bit : ~busy);

endmodule

// File: rtl/mw_eeprom_checker.sv
// Temporal checks on the serial EEPROM model, attached by bind.
// Assumes the internal strobe and status names of mw_eeprom.
module mw_eeprom_checker #(
    parameter int PROG_CYCLES = 600
) (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic busy,
    input logic prog_go,
    input logic wen,
    input logic read_active,
    input logic dout
);

    int busy_run;

    // Length of the current busy stretch in clocks
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    assert_launch_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> !busy);

    assert_launch_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> wen);

    assert_busy_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(prog_go));

    assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == PROG_CYCLES));

    assert_busy_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && busy && !read_active) |-> !dout);

    assert_quiet_line_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |-> !dout);

endmodule

bind mw_eeprom mw_eeprom_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_s        (cs_s),
    .busy        (busy),
    .prog_go     (prog_go),
    .wen         (wen),
    .read_active (read_active),
    .dout        (dout)
);

// File: tb/mw_eeprom_test.sv
// Sweep bench for mw_eeprom with a short programming time.
module mw_eeprom_test;

    localparam int AW    = 7;
    localparam int DW    = 8;
    localparam int PROG  = 60;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic dout;

    always #5 clk = ~clk;

    mw_eeprom #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PROG)) uut (
        .clk (clk), .rst_n (rst_n), .cs (cs), .sk (sk), .di (di), .dout (dout)
    );

    int total = 0, bad = 0;
    longint cyc = 0;
    logic [7:0] model [DEPTH];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(logic b);
        di = b; idle(4); sk = 1'b1; idle(4); sk = 1'b0;
    endtask

    task automatic pulse();
        idle(4); sk = 1'b1; idle(4); sk = 1'b0; idle(4);
    endtask

    task automatic cs_up();
        cs = 1'b1; idle(4);
    endtask

    task automatic cs_down();
        di = 1'b0; cs = 1'b0; idle(4);
    endtask

    task automatic send_hdr(logic [1:0] op, logic [6:0] a);
        bit_out(1'b1); bit_out(op[1]); bit_out(op[0]);
        for (int i = 6; i >= 0; i--) bit_out(a[i]);
    endtask

    task automatic send_byte(logic [7:0] d);
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
    endtask

    // Drop chip select, then watch ready/busy after raising it again
    task automatic prog_finish(string req, bit expect_busy);
        longint t0;
        int n;
        t0 = cyc;
        di = 1'b0; cs = 1'b0; idle(4);
        check("R13 dout low with cs low", dout, 0);
        cs = 1'b1; idle(2);
        if (expect_busy) begin
            check(req, dout, 0);
            n = 0;
            while (dout !== 1'b1 && n < 2000) begin idle(1); n++; end
            check("R5 busy length", ((cyc - t0) >= PROG + 1) && ((cyc - t0) <= PROG + 3), 1);
        end else begin
            check(req, dout, 1);
        end
        cs_down();
    endtask

    task automatic write_loc(logic [6:0] a, logic [7:0] d, string req, bit expect_busy);
        cs_up(); send_hdr(2'b01, a); send_byte(d);
        prog_finish(req, expect_busy);
    endtask

    task automatic read_loc(logic [6:0] a, int zeros, output logic [7:0] v, output logic dummy);
        cs_up();
        for (int i = 0; i < zeros; i++) bit_out(1'b0);
        send_hdr(2'b10, a);
        idle(3);
        dummy = dout;
        v = '0;
        for (int i = 0; i < 8; i++) begin pulse(); v = {v[6:0], dout}; end
        cs_down();
    endtask

    task automatic ext_cmd(logic [1:0] code);
        cs_up(); send_hdr(2'b00, {code, 5'b0});
    endtask

    task automatic sweep_check(string req);
        logic [7:0] v;
        logic dm;
        for (int a = 0; a < DEPTH; a++) begin
            read_loc(a[6:0], 0, v, dm);
            check(req, v, model[a]);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic dm;
        for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
        idle(5); rst_n = 1'b1; idle(3);

        // R13 / R1: quiet line, then ready after reset
        check("R13 dout with cs low after reset", dout, 0);
        cs_up(); check("R1 ready after reset", dout, 1); cs_down();
        read_loc(7'd0, 0, v, dm);   check("R1 erased loc 0", v, 8'hFF);
        check("R4 dummy bit", dm, 0);
        read_loc(7'd127, 0, v, dm); check("R1 erased loc 127", v, 8'hFF);

        // R2: locked after reset, all programming ignored
        write_loc(7'd5, 8'h12, "R2 locked write not busy", 0);
        cs_up(); send_hdr(2'b11, 7'd6); prog_finish("R2 locked erase not busy", 0);
        ext_cmd(2'b01); send_byte(8'h00); prog_finish("R2 locked write-all not busy", 0);
        ext_cmd(2'b10); prog_finish("R2 locked erase-all not busy", 0);
        read_loc(7'd5, 0, v, dm); check("R2 locked write no change", v, 8'hFF);

        // R11: unlock, no busy
        ext_cmd(2'b11); prog_finish("R11 unlock not busy", 0);

        // R6 / R5: exhaustive write sweep with arithmetic pattern
        for (int a = 0; a < DEPTH; a++) begin
            model[a] = 8'((a * 37 + 5) & 255);
            write_loc(a[6:0], model[a], "R6 write busy", 1);
        end
        // R4 / R6: read back every location
        sweep_check("R6 write readback");

        // R3: leading zeros before the start bit are skipped
        read_loc(7'd77, 3, v, dm);
        check("R3 leading zeros read", v, model[77]);
        check("R4 dummy after zeros", dm, 0);

        // R8: single erase leaves neighbours
        cs_up(); send_hdr(2'b11, 7'd10); prog_finish("R8 erase busy", 1);
        model[10] = 8'hFF;
        read_loc(7'd10, 0, v, dm); check("R8 erased", v, 8'hFF);
        read_loc(7'd9, 0, v, dm);  check("R8 neighbour low", v, model[9]);
        read_loc(7'd11, 0, v, dm); check("R8 neighbour high", v, model[11]);

        // R7: instruction started while busy is ignored
        model[20] = 8'hC3;
        cs_up(); send_hdr(2'b01, 7'd20); send_byte(8'hC3);
        cs_down();
        cs_up(); send_hdr(2'b01, 7'd21); send_byte(8'h00);
        prog_finish("R7 ignored write not busy", 0);
        read_loc(7'd20, 0, v, dm); check("R7 first write lands", v, 8'hC3);
        read_loc(7'd21, 0, v, dm); check("R7 busy write ignored", v, model[21]);

        // R12: aborted write
        cs_up(); send_hdr(2'b01, 7'd30); bit_out(1'b0); bit_out(1'b0); bit_out(1'b0);
        prog_finish("R12 abort not busy", 0);
        read_loc(7'd30, 0, v, dm); check("R12 abort no change", v, model[30]);

        // R10: write-all
        ext_cmd(2'b01); send_byte(8'h5A); prog_finish("R10 write-all busy", 1);
        for (int a = 0; a < DEPTH; a++) model[a] = 8'h5A;
        sweep_check("R10 write-all readback");

        // R9: erase-all
        ext_cmd(2'b10); prog_finish("R9 erase-all busy", 1);
        for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
        sweep_check("R9 erase-all readback");

        // R11: lock again, writes ignored
        write_loc(7'd3, 8'h81, "R11 write while unlocked", 1);
        model[3] = 8'h81;
        ext_cmd(2'b00); prog_finish("R11 lock not busy", 0);
        write_loc(7'd3, 8'h00, "R11 locked write not busy", 0);
        read_loc(7'd3, 0, v, dm); check("R11 locked keeps value", v, 8'h81);
        check("R13 dout low at end", dout, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule